// File: doc/BRIEF.md
# Access Alignment Gate

The gate sits between a 64-bit pipeline's load/store and fetch ports and the memory interface. It takes one request per handshake: an address, a size code, whether the request is an instruction fetch, whether the target is Device-type memory, and an alignment-strictness control bit for the current privilege level. It either rejects the request with a fault code in the acceptance cycle, or forwards it to memory as one or two beats. Each beat covers one aligned window of `WIN_BYTES` bytes (16 by default) and carries a byte-lane mask.

Fetches must sit on a 4-byte boundary. Device memory never tolerates a misaligned data access. Normal memory tolerates one only while the strictness bit is clear. A tolerated access that straddles a window boundary is cut into a lower beat and an upper beat, issued in that order. The two beats are separate memory transfers, so the access as a whole is not single-copy atomic. Aligned traffic goes straight through in the cycle it arrives.

Top module: `align_gate`

## Requirements
- R1: A fetch (`req_fetch`=1) whose address has bit 1 or bit 0 set is rejected with code 1. A fetch always spans 4 bytes, and its size field is ignored.
- R2: A misaligned data access to Device memory (`req_device`=1) is rejected with code 2, whether `req_chk_en` is 0 or 1.
- R3: A misaligned data access to Normal memory with `req_chk_en`=1 is rejected with code 3.
- R4: A rejection is signalled in the cycle the request is offered: `flt_valid`=1 and `req_ready`=1, and no beat is issued. When `flt_valid`=0, `flt_code` reads 0.
- R5: An access contained in one window is issued as a single beat in the cycle it is offered. That beat has `beat_last`=1 and `beat_addr` = address with its low log2(`WIN_BYTES`) bits cleared. The request is accepted (`req_ready`=1) in the same cycle that `beat_ready`=1.
- R6: A misaligned Normal data access with `req_chk_en`=0 that stays inside one window is issued as a single beat, with no fault.
- R7: A tolerated access that crosses a window boundary produces two beats. The first beat is at the lower window with `beat_last`=0. The second beat is at the lower window + `WIN_BYTES` with `beat_last`=1, and it is issued in the cycle after the first beat is taken.
- R8: Bit k of `beat_be` enables byte lane k, at address `beat_addr`+k. Across the beats of one access, the set bits cover exactly the requested bytes, with no lane repeated.
- R9: While the second beat is pending, `req_ready` and `flt_valid` stay 0, whatever request is offered.
- R10: A beat that is not taken (`beat_ready`=0) is held unchanged in the next cycle.
- R11: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 behave as 16 bytes. An access is misaligned when its address is not a multiple of its byte count.
- R12: During and straight after reset, no beat and no fault are signalled while `req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 3 | log2 of the byte count |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_device | input | 1 | 1 = Device memory, 0 = Normal |
| req_chk_en | input | 1 | Strict alignment for Normal data |
| flt_valid | output | 1 | Request rejected this cycle |
| flt_code | output | 2 | 0 none, 1 fetch, 2 device, 3 strict |
| beat_valid | output | 1 | Beat offered to memory |
| beat_ready | input | 1 | Memory takes the beat |
| beat_addr | output | ADDR_W | Window-aligned beat address |
| beat_be | output | WIN_BYTES | Byte-lane enables of the beat |
| beat_last | output | 1 | Final beat of the access |

## Verification
The only internal state is the pending upper beat. If that state is wrong, the port contract breaks in the very next cycle. A tail that is lost shows up as `req_ready` rising again after a `beat_last`=0 beat. A tail that goes stale or gets overwritten shows up as a wrong address or lane mask on the second beat. A tail that is stuck shows up as a second beat that never drops when `beat_ready` is high, or as an offered request that is never accepted. The bench offers a faulting request while each tail is pending, so a gate that leaks requests through shows up as an early `req_ready` or a stray `flt_valid` in that same cycle.

// File: rtl/align_pkg.sv
package align_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_FETCH  = 2'd1,
        FLT_DEVICE = 2'd2,
        FLT_STRICT = 2'd3
    } flt_code_e;

    typedef enum logic {
        SEQ_HEAD = 1'b0,
        SEQ_TAIL = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic      fault;
        flt_code_e code;
        logic      split;
    } verdict_t;

    localparam logic [2:0] FETCH_LOG2 = 3'd2;
    localparam logic [2:0] MAX_LOG2   = 3'd4;

    // Size codes beyond the largest supported access saturate to it.
    function automatic logic [2:0] eff_log2(input logic [2:0] size, input logic fetch);
        if (fetch)
            return FETCH_LOG2;
        return (size > MAX_LOG2) ? MAX_LOG2 : size;
    endfunction

endpackage

// File: rtl/align_classify.sv
module align_classify
    import align_pkg::*;
#(
    parameter int WIN_BYTES = 16,
    localparam int OFF_W = $clog2(WIN_BYTES)
) (
    input  logic [OFF_W-1:0] low,
    input  logic [2:0]       size,
    input  logic             fetch,
    input  logic             device,
    input  logic             chk_en,
    output logic [OFF_W:0]   nbytes,
    output verdict_t         verdict
);
    logic [2:0]       lg;
    logic [OFF_W-1:0] lane_mask;
    logic [OFF_W:0]   span_end;
    logic             misaligned;
    logic             crosses;

    always_comb begin
        lg         = eff_log2(size, fetch);
        nbytes     = (OFF_W+1)'(1) << lg;
        lane_mask  = OFF_W'(nbytes - (OFF_W+1)'(1));
        misaligned = |(low & lane_mask);
        span_end   = {1'b0, low} + nbytes;
        crosses    = span_end > (OFF_W+1)'(WIN_BYTES);

        verdict = '{fault: 1'b0, code: FLT_NONE, split: 1'b0};
        if (misaligned) begin
            if (fetch)
                verdict = '{fault: 1'b1, code: FLT_FETCH, split: 1'b0};
            else if (device)
                verdict = '{fault: 1'b1, code: FLT_DEVICE, split: 1'b0};
            else if (chk_en)
                verdict = '{fault: 1'b1, code: FLT_STRICT, split: 1'b0};
            else
                verdict.split = crosses;
        end
    end
endmodule

// File: rtl/byte_lanes.sv
module byte_lanes #(
    parameter int WIN_BYTES = 16,
    localparam int OFF_W = $clog2(WIN_BYTES),
    localparam int SPAN = 2 * WIN_BYTES
) (
    input  logic [OFF_W-1:0] low,
    input  logic [OFF_W:0]   nbytes,
    output logic [SPAN-1:0]  lanes
);
    logic [OFF_W:0] first;
    logic [OFF_W:0] stop;

    assign first = {1'b0, low};
    assign stop  = first + nbytes;

    for (genvar i = 0; i < SPAN; i++) begin : g_lane
        localparam logic [OFF_W:0] LANE = (OFF_W+1)'(i);
        assign lanes[i] = (LANE >= first) && (LANE < stop);
    end
endmodule

// File: rtl/align_gate.sv
module align_gate
    import align_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int WIN_BYTES = 16,
    localparam int OFF_W = $clog2(WIN_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2:0]           req_size,
    input  logic                 req_fetch,
    input  logic                 req_device,
    input  logic                 req_chk_en,
    output logic                 flt_valid,
    output logic [1:0]           flt_code,
    output logic                 beat_valid,
    input  logic                 beat_ready,
    output logic [ADDR_W-1:0]    beat_addr,
    output logic [WIN_BYTES-1:0] beat_be,
    output logic                 beat_last
);
    seq_state_e              state_q;
    logic [ADDR_W-1:0]       tail_addr_q;
    logic [WIN_BYTES-1:0]    tail_be_q;

    verdict_t                verdict;
    logic [OFF_W:0]          nbytes;
    logic [2*WIN_BYTES-1:0]  lanes;
    logic [ADDR_W-1:0]       base;

    align_classify #(.WIN_BYTES(WIN_BYTES)) u_classify (
        .low     (req_addr[OFF_W-1:0]),
        .size    (req_size),
        .fetch   (req_fetch),
        .device  (req_device),
        .chk_en  (req_chk_en),
        .nbytes  (nbytes),
        .verdict (verdict)
    );

    byte_lanes #(.WIN_BYTES(WIN_BYTES)) u_lanes (
        .low    (req_addr[OFF_W-1:0]),
        .nbytes (nbytes),
        .lanes  (lanes)
    );

    assign base = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    always_comb begin
        req_ready  = 1'b0;
        flt_valid  = 1'b0;
        flt_code   = FLT_NONE;
        beat_valid = 1'b0;
        beat_addr  = base;
        beat_be    = lanes[WIN_BYTES-1:0];
        beat_last  = 1'b1;
        if (state_q == SEQ_TAIL) begin
            beat_valid = 1'b1;
            beat_addr  = tail_addr_q;
            beat_be    = tail_be_q;
        end else if (req_valid) begin
            if (verdict.fault) begin
                req_ready = 1'b1;
                flt_valid = 1'b1;
                flt_code  = verdict.code;
            end else begin
                beat_valid = 1'b1;
                beat_last  = ~verdict.split;
                req_ready  = beat_ready;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_HEAD;
            tail_addr_q <= '0;
            tail_be_q   <= '0;
        end else if (state_q == SEQ_TAIL) begin
            if (beat_ready)
                state_q <= SEQ_HEAD;
        end else if (req_valid && !verdict.fault && verdict.split && beat_ready) begin
            state_q     <= SEQ_TAIL;
            tail_addr_q <= base + ADDR_W'(WIN_BYTES);
            tail_be_q   <= lanes[2*WIN_BYTES-1:WIN_BYTES];
        end
    end
endmodule

// File: rtl/align_gate_chk.sv
module align_gate_chk #(
    parameter int ADDR_W    = 64,
    parameter int WIN_BYTES = 16,
    localparam int OFF_W = $clog2(WIN_BYTES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_fetch,
    input logic                 req_device,
    input logic                 req_chk_en,
    input logic                 flt_valid,
    input logic [1:0]           flt_code,
    input logic                 beat_valid,
    input logic                 beat_ready,
    input logic [ADDR_W-1:0]    beat_addr,
    input logic [WIN_BYTES-1:0] beat_be,
    input logic                 beat_last
);
    a_r4_fault_excludes_beat: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> (req_ready && !beat_valid && req_valid));

    a_r1_fetch_misaligned: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_fetch && (req_addr[1:0] != 2'b00))
            |-> (flt_valid && flt_code == 2'd1));

    a_r2_device_code: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !req_fetch && req_device) |-> (flt_code == 2'd2));

    a_r3_strict_code: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !req_fetch && !req_device) |-> (flt_code == 2'd3 && req_chk_en));

    a_r9_tail_blocks: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last)
            |=> (beat_valid && beat_last && !req_ready && !flt_valid));

    a_r7_tail_addr: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && !beat_last)
            |=> (beat_addr == $past(beat_addr) + ADDR_W'(WIN_BYTES)));

    a_r8_lanes_nonempty: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_be != '0));

    a_r5_window_aligned: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_addr[OFF_W-1:0] == '0));

    a_r10_tail_hold: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_last && !req_ready && !beat_ready)
            |=> (beat_valid && $stable(beat_addr) && $stable(beat_be)));
endmodule

bind align_gate align_gate_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_fetch  (req_fetch),
    .req_device (req_device),
    .req_chk_en (req_chk_en),
    .flt_valid  (flt_valid),
    .flt_code   (flt_code),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_be    (beat_be),
    .beat_last  (beat_last)
);

// File: tb/align_gate_test.sv
module align_gate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_fetch = 1'b0;
    logic        req_device = 1'b0;
    logic        req_chk_en = 1'b0;
    logic        flt_valid;
    logic [1:0]  flt_code;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [63:0] beat_addr;
    logic [15:0] beat_be;
    logic        beat_last;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    align_gate uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_fetch(req_fetch), .req_device(req_device),
        .req_chk_en(req_chk_en), .flt_valid(flt_valid), .flt_code(flt_code),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
        .beat_be(beat_be), .beat_last(beat_last)
    );

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output of one cycle against the model's expectation.
    task automatic observe(input string tag, input bit bv, input logic [63:0] ba,
                           input logic [15:0] be, input bit last, input bit rr,
                           input bit fv, input logic [1:0] fc);
        cmp({tag, " beat_valid"}, 64'(beat_valid), 64'(bv));
        cmp({tag, " req_ready"},  64'(req_ready),  64'(rr));
        cmp({tag, " flt_valid"},  64'(flt_valid),  64'(fv));
        cmp({tag, " flt_code"},   64'(flt_code),   64'(fc));
        if (bv) begin
            cmp({tag, " beat_addr"}, beat_addr, ba);
            cmp({tag, " beat_be"},   64'(beat_be),   64'(be));
            cmp({tag, " beat_last"}, 64'(beat_last), 64'(last));
        end
    endtask

    task automatic run(input string tag, input logic [63:0] a, input logic [2:0] sz,
                       input bit f, input bit d, input bit c, input int stall);
        int n;
        int off;
        int code;
        logic [31:0] lanes;
        logic [63:0] base;
        bit two;
        n     = f ? 4 : ((sz > 3'd4) ? 16 : (1 << sz));
        off   = int'(a % 64'd16);
        code  = 0;
        if ((a % 64'(n)) != 0) code = f ? 1 : (d ? 2 : (c ? 3 : 0));
        lanes = '0;
        for (int i = 0; i < n; i++) lanes[off + i] = 1'b1;
        base  = a & ~64'hF;
        two   = (lanes[31:16] != 16'h0);

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz;
        req_fetch = f; req_device = d; req_chk_en = c; beat_ready = 1'b0;
        if (code != 0) begin
            #1 observe(tag, 1'b0, '0, '0, 1'b0, 1'b1, 1'b1, 2'(code));
            @(negedge clk);
            req_valid = 1'b0;
            return;
        end
        for (int s = 0; s < stall; s++) begin
            #1 observe({tag, " R10 stall"}, 1'b1, base, lanes[15:0], !two, 1'b0, 1'b0, 2'd0);
            @(negedge clk);
        end
        beat_ready = 1'b1;
        #1 observe(tag, 1'b1, base, lanes[15:0], !two, 1'b1, 1'b0, 2'd0);
        @(negedge clk);
        if (two) begin
            // A faulting fetch is offered while the upper beat waits (R9).
            req_addr = 64'h3; req_fetch = 1'b1; beat_ready = 1'b0;
            #1 observe({tag, " R9 tail hold"}, 1'b1, base + 64'd16, lanes[31:16], 1'b1,
                       1'b0, 1'b0, 2'd0);
            @(negedge clk);
            beat_ready = 1'b1;
            #1 observe({tag, " R7 tail"}, 1'b1, base + 64'd16, lanes[31:16], 1'b1,
                       1'b0, 1'b0, 2'd0);
            @(negedge clk);
        end
        req_valid = 1'b0; beat_ready = 1'b0; req_fetch = 1'b0;
        #1 observe({tag, " idle"}, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 2'd0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 observe("R12 in reset", 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 2'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1 observe("R12 after reset", 1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 2'd0);

        run("R5 fetch aligned",          64'h1000, 3'd0, 1, 0, 1, 0);
        run("R1 fetch ignores size R11", 64'h1004, 3'd4, 1, 0, 0, 1);
        run("R1 fetch bit1",             64'h1002, 3'd2, 1, 0, 0, 0);
        run("R1 fetch bit0",             64'h1001, 3'd0, 1, 0, 0, 0);
        run("R5 device aligned dword",   64'h2008, 3'd3, 0, 1, 1, 0);
        run("R2 device chk off",         64'h2002, 3'd2, 0, 1, 0, 0);
        run("R2 device chk on",          64'h2002, 3'd2, 0, 1, 1, 0);
        run("R3 normal strict",          64'h2006, 3'd3, 0, 0, 1, 0);
        run("R6 normal in window",       64'h3005, 3'd1, 0, 0, 0, 2);
        run("R7 R8 dword cross",         64'h300C, 3'd3, 0, 0, 0, 0);
        run("R7 R8 quad cross stall",    64'h4001, 3'd4, 0, 0, 0, 1);
        run("R11 code5 aligned",         64'h5000, 3'd5, 0, 0, 1, 0);
        run("R11 code7 cross",           64'h5008, 3'd7, 0, 0, 0, 0);
        run("R5 byte top lane strict",   64'h600F, 3'd0, 0, 0, 1, 0);
        run("R3 R4 halfword strict",     64'h6001, 3'd1, 0, 0, 1, 0);
        run("R8 word cross device off",  64'h700E, 3'd2, 0, 0, 0, 3);
        finish_run();
    end
endmodule